// File: doc/BRIEF.md
# Serial Port Status LED Streamer

This block gathers status from a multiport repeater and sends it to an external display as four serial byte streams. From the reference clock it divides a shift clock at half the rate. It frames the bits eight at a time and raises a latch strobe once per frame. An external shift register clocked on the rising shift-clock edge collects the bits. A storage register clocked on the rising edge that falls inside the latch pulse then holds each byte in parallel.

The four streams are:
- twisted-pair link state, with a visible blink stretched from short receive activity;
- twisted-pair partition state;
- error flags for the two AUI ports;
- a thermometer of bandwidth utilization, measured by counting carrier-active bit times over a fixed window.

Every status input is a level from neighbouring logic. Each byte is snapshotted at the start of its frame, so all four streams of a frame show the same instant.

Top module: `led_status_streamer`

## Requirements
- R1: While rst_ni is low, tck_o and latch_o are low and the four serial data outputs are high.
- R2: tck_o toggles on every clk_i cycle. The serial data outputs and latch_o change only at clk_i edges where tck_o falls.
- R3: Each frame is 8 shift-clock periods and carries its byte bit 7 first. At the falling edge that ends the eighth bit, latch_o goes high for exactly one shift-clock period (2 clk_i cycles), so it rises once every 16 clk_i cycles. The frame loaded right after reset is not latched.
- R4: Partition byte bit n equals the inverse of part_i[n]: a partitioned port reads 0.
- R5: Link byte bit n is 1 when link_fail_i[n] is high or when port n shows its receive blink. Otherwise it is 0.
- R6: If rx_act_i[n] is high while port n is idle, its blink is high for STRETCH_ON_CYC cycles. The port then ignores receive activity for STRETCH_OFF_CYC cycles before it can blink again. Each port is independent.
- R7: The AUI byte is the bitwise inverse of aui_err_i. Port 1 uses bits 0..3 and port 2 uses bits 4..7. In each nibble, bit 0 is partition, bit 1 is bit-rate error, bit 2 is jabber and bit 3 is loopback error.
- R8: crs_i is sampled once per shift-clock period. The number of high samples over 2^WIN_LOG2 samples is compared at the end of the window and held until the next window ends.
- R9: Traffic byte bit k is 0 when the window count is strictly greater than floor(W·f_k), where W = 2^WIN_LOG2 and f_0..f_7 = 1/100, 1/16, 1/8, 1/4, 3/8, 1/2, 5/8, 7/8. After reset, before the first window ends, the byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (twice the shift rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_fail_i | input | NUM_TP | Per-port link test failed |
| rx_act_i | input | NUM_TP | Per-port receive activity level |
| part_i | input | NUM_TP | Per-port partitioned |
| aui_err_i | input | 8 | AUI error flags, active high, nibble per port |
| crs_i | input | 1 | Repeater carrier active |
| tck_o | output | 1 | Shift clock |
| latch_o | output | 1 | Byte latch strobe |
| link_sd_o | output | 1 | Link/receive serial data |
| part_sd_o | output | 1 | Partition serial data |
| aui_sd_o | output | 1 | AUI status serial data |
| traf_sd_o | output | 1 | Traffic serial data |

## Verification
The timing is as follows:
- The shift clock responds on the first clk_i edge, and the blink starts one cycle after the activity.
- A byte is loaded at a frame start and reaches the external storage register 16 cycles later.
- A change on a status input is therefore certain to appear only in the second latched byte after it.
- A traffic result also needs one whole window of 2^(WIN_LOG2+1) cycles under the new pattern before it is latched.

The bench rebuilds the external shift and storage registers from tck_o and latch_o. Each check waits for a capture count after the stimulus rather than a fixed cycle count. Traffic checks first wait for two windows. Blink and blind-window checks are placed at known offsets inside the stretched intervals.

// File: rtl/led_stream_pkg.sv
package led_stream_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NUM_THR = 8;
  localparam int unsigned NUM_STR = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SHOW, ST_HOLD} blink_st_e;

  // utilization thresholds, fraction of window, ascending
  function automatic int unsigned thr_of(int unsigned idx, int unsigned win);
    case (idx)
      0:       return win / 100;
      1:       return win / 16;
      2:       return win / 8;
      3:       return win / 4;
      4:       return (win * 3) / 8;
      5:       return win / 2;
      6:       return (win * 5) / 8;
      default: return (win * 7) / 8;
    endcase
  endfunction
endpackage

// File: rtl/led_tck_gen.sv
module led_tck_gen #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tck_o,
  output logic load_o,
  output logic shift_o,
  output logic latch_o
);
  localparam int unsigned SLOT_W = $clog2(BYTE_W);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(BYTE_W - 1);

  logic              tck_q;
  logic [SLOT_W-1:0] slot_q;
  logic              armed_q;
  logic              latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_q   <= 1'b0;
      slot_q  <= LAST;
      armed_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      tck_q <= ~tck_q;
      if (tck_q) begin
        latch_q <= (slot_q == LAST) && armed_q;
        if (slot_q == LAST) begin
          slot_q  <= '0;
          armed_q <= 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  assign tck_o   = tck_q;
  assign load_o  = tck_q && (slot_q == LAST);
  assign shift_o = tck_q && (slot_q != LAST);
  assign latch_o = latch_q;

  AST_TCK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (tck_q != $past(tck_q))); // R2
  AST_LATCH_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(latch_q) |-> $fell(tck_q)); // R2
  AST_LATCH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |=> latch_q ##1 !latch_q); // R3
endmodule

// File: rtl/led_rx_stretch.sv
module led_rx_stretch #(
  parameter int unsigned ON_CYC  = 1560000,
  parameter int unsigned OFF_CYC = 1040000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic blink_o
);
  import led_stream_pkg::*;

  localparam int unsigned MAX_C = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  blink_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (act_i) begin
          st_q  <= ST_SHOW;
          cnt_q <= CNT_W'(ON_CYC - 1);
        end
        ST_SHOW: if (cnt_q == '0) begin
          st_q  <= ST_HOLD;
          cnt_q <= CNT_W'(OFF_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_HOLD: if (cnt_q == '0) st_q <= ST_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign blink_o = (st_q == ST_SHOW);

  AST_SHOW_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHOW) |=> (st_q != ST_IDLE)); // R6
  AST_HOLD_BLIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && cnt_q != '0) |=> (st_q == ST_HOLD)); // R6
endmodule

// File: rtl/led_util_meter.sv
module led_util_meter #(
  parameter int unsigned WIN_LOG2 = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       crs_i,
  output logic [7:0] over_o
);
  import led_stream_pkg::*;

  localparam int unsigned WIN   = 1 << WIN_LOG2;
  localparam int unsigned CNT_W = WIN_LOG2 + 1;

  logic [WIN_LOG2-1:0] tick_cnt_q;
  logic [CNT_W-1:0]    act_cnt_q;
  logic [CNT_W-1:0]    act_next;
  logic [NUM_THR-1:0]  over_d;
  logic [NUM_THR-1:0]  over_q;

  assign act_next = act_cnt_q + CNT_W'(crs_i);

  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    localparam int unsigned THR = thr_of(k, WIN);
    assign over_d[k] = act_next > CNT_W'(THR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
      act_cnt_q  <= '0;
      over_q     <= '0;
    end else if (tick_i) begin
      tick_cnt_q <= tick_cnt_q + 1'b1;
      if (&tick_cnt_q) begin
        over_q    <= over_d;
        act_cnt_q <= '0;
      end else begin
        act_cnt_q <= act_next;
      end
    end
  end

  assign over_o = over_q;

  AST_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((over_q + 1'b1) & over_q) == '0); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_cnt_q <= {1'b0, tick_cnt_q}); // R8
endmodule

// File: rtl/led_status_streamer.sv
module led_status_streamer #(
  parameter int unsigned NUM_TP         = 8,
  parameter int unsigned STRETCH_ON_CYC  = 1560000,
  parameter int unsigned STRETCH_OFF_CYC = 1040000,
  parameter int unsigned WIN_LOG2       = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_TP-1:0] link_fail_i,
  input  logic [NUM_TP-1:0] rx_act_i,
  input  logic [NUM_TP-1:0] part_i,
  input  logic [7:0]        aui_err_i,
  input  logic              crs_i,
  output logic              tck_o,
  output logic              latch_o,
  output logic              link_sd_o,
  output logic              part_sd_o,
  output logic              aui_sd_o,
  output logic              traf_sd_o
);
  import led_stream_pkg::*;

  logic              load, shift;
  logic [NUM_TP-1:0] blink;
  logic [7:0]        over;
  logic [NUM_STR-1:0][BYTE_W-1:0] byte_d;
  logic [NUM_STR-1:0][BYTE_W-1:0] sr_q;

  led_tck_gen #(.BYTE_W(BYTE_W)) u_tck (
    .clk_i, .rst_ni, .tck_o, .load_o(load), .shift_o(shift), .latch_o
  );

  for (genvar p = 0; p < NUM_TP; p++) begin : g_port
    led_rx_stretch #(.ON_CYC(STRETCH_ON_CYC), .OFF_CYC(STRETCH_OFF_CYC)) u_str (
      .clk_i, .rst_ni, .act_i(rx_act_i[p]), .blink_o(blink[p])
    );
  end

  led_util_meter #(.WIN_LOG2(WIN_LOG2)) u_util (
    .clk_i, .rst_ni, .tick_i(tck_o), .crs_i, .over_o(over)
  );

  assign byte_d[0] = BYTE_W'(link_fail_i | blink);
  assign byte_d[1] = BYTE_W'(~part_i);
  assign byte_d[2] = ~aui_err_i;
  assign byte_d[3] = ~over;

  for (genvar s = 0; s < NUM_STR; s++) begin : g_str
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sr_q[s] <= '1;
      else if (load)  sr_q[s] <= byte_d[s];
      else if (shift) sr_q[s] <= {sr_q[s][BYTE_W-2:0], 1'b1};
    end

    AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sr_q[s][BYTE_W-1]) |-> $fell(tck_o)); // R2
  end

  assign link_sd_o = sr_q[0][BYTE_W-1];
  assign part_sd_o = sr_q[1][BYTE_W-1];
  assign aui_sd_o  = sr_q[2][BYTE_W-1];
  assign traf_sd_o = sr_q[3][BYTE_W-1];

  AST_STROBE_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_o) |-> $fell(tck_o)); // R3
endmodule

// File: tb/sim_led_status_streamer.sv
module sim_led_status_streamer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] link_fail = '0, rx_act = '0, part = '0, aui_err = '0;
  logic       crs = 1'b0;
  logic       tck, latch, link_sd, part_sd, aui_sd, traf_sd;

  always #2.5 clk = ~clk;

  led_status_streamer #(
    .NUM_TP(8), .STRETCH_ON_CYC(200), .STRETCH_OFF_CYC(200), .WIN_LOG2(6)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .link_fail_i(link_fail), .rx_act_i(rx_act),
    .part_i(part), .aui_err_i(aui_err), .crs_i(crs), .tck_o(tck),
    .latch_o(latch), .link_sd_o(link_sd), .part_sd_o(part_sd),
    .aui_sd_o(aui_sd), .traf_sd_o(traf_sd)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // carrier duty pattern in sixteenths of clk cycles
  int duty = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    crs <= (cyc % 16) < duty;
  end

  // external shift + storage registers
  logic [7:0] sr_l, sr_p, sr_a, sr_t;
  logic [7:0] cap_l, cap_p, cap_a, cap_t;
  int cap_cnt = 0;
  always @(posedge tck) begin
    if (latch) begin
      cap_l <= sr_l; cap_p <= sr_p; cap_a <= sr_a; cap_t <= sr_t;
      cap_cnt <= cap_cnt + 1;
    end
    sr_l <= {sr_l[6:0], link_sd};
    sr_p <= {sr_p[6:0], part_sd};
    sr_a <= {sr_a[6:0], aui_sd};
    sr_t <= {sr_t[6:0], traf_sd};
  end

  // latch width and period
  int hi_run = 0, last_run = 0, since_rise = 0, last_period = 0;
  logic latch_d = 1'b0;
  always @(negedge clk) begin
    if (latch) hi_run++;
    else if (hi_run != 0) begin last_run = hi_run; hi_run = 0; end
    since_rise++;
    if (latch && !latch_d) begin last_period = since_rise; since_rise = 0; end
    latch_d = latch;
  end

  task automatic wait_caps(int n);
    int c0 = cap_cnt;
    wait (cap_cnt >= c0 + n);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] lf, pt, ae, dt, el, ep, ea, et;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{8'h00, 8'h00, 8'h00, 8'd0,  8'h00, 8'hFF, 8'hFF, 8'hFF},
    '{8'hA5, 8'h0F, 8'h81, 8'd8,  8'hA5, 8'hF0, 8'h7E, 8'hE0},
    '{8'h01, 8'h80, 8'h0F, 8'd4,  8'h01, 8'h7F, 8'hF0, 8'hF8},
    '{8'hFF, 8'hFF, 8'h96, 8'd14, 8'hFF, 8'h00, 8'h69, 8'h80},
    '{8'h80, 8'h01, 8'h00, 8'd16, 8'h80, 8'hFE, 8'hFF, 8'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tck", {7'b0, tck}, 8'h00);
    chk("R1 latch", {7'b0, latch}, 8'h00);
    chk("R1 data", {4'b0, link_sd, part_sd, aui_sd, traf_sd}, 8'h0F);
    rst_n = 1'b1;
    // R2 shift clock toggles each cycle
    begin
      logic t0;
      @(negedge clk); t0 = tck;
      @(negedge clk); chk("R2 tck toggle", {7'b0, tck}, {7'b0, ~t0});
    end
    // R3: first frame not latched
    repeat (15) @(negedge clk);
    chk("R3 first frame unlatched", 8'(cap_cnt), 8'd0);

    for (int i = 0; i < 5; i++) begin
      link_fail = VEC[i].lf; part = VEC[i].pt; aui_err = VEC[i].ae;
      duty = int'(VEC[i].dt);
      repeat (300) @(negedge clk);
      wait_caps(2);
      chk($sformatf("R5 link v%0d", i), cap_l, VEC[i].el);
      chk($sformatf("R4 part v%0d", i), cap_p, VEC[i].ep);
      chk($sformatf("R7 aui v%0d", i), cap_a, VEC[i].ea);
      chk($sformatf("R9 R8 traffic v%0d", i), cap_t, VEC[i].et);
    end

    // R3 latch width and period
    chk("R3 latch width", 8'(last_run), 8'd2);
    chk("R3 latch period", 8'(last_period), 8'd16);

    // R6 receive blink, blind window, per-port independence
    link_fail = '0;
    @(negedge clk); rx_act = 8'h08;
    @(negedge clk); rx_act = '0;
    wait_caps(2);
    chk("R6 blink on", cap_l, 8'h08);
    repeat (200) @(negedge clk);
    rx_act = 8'h08;
    @(negedge clk); rx_act = '0;
    wait_caps(2);
    chk("R6 ignored in blind window", cap_l, 8'h00);
    repeat (150) @(negedge clk);
    link_fail = 8'h10;
    rx_act = 8'h81;
    @(negedge clk); rx_act = '0;
    wait_caps(2);
    chk("R6 R5 blink again with fail", cap_l, 8'h91);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule